// File: doc/BRIEF.md
# Dual-channel PWM controller with coded prescaler

This peripheral produces up to two pulse-width-modulated outputs and is programmed over a plain 32-bit register bus. Writes are single-cycle strobes and reads are combinational. One shared control word holds a 10-bit configuration field for each channel. The field for channel n starts at bit 15·n. Each channel also has a period/duty word. Every channel divides the block clock by a prescaler chosen from a fixed coded table, or it uses the clock undivided. The result is a stream of prescaled ticks. The period and the active phase are counted in those ticks.

Software writes a period/duty word into a shadow copy. The running counters take the new value only when the current period ends, so a waveform never shows a torn period. A per-channel ready flag in the control word shows that a shadow value is still waiting to be taken. A channel can run continuously, or it can emit exactly one period and then drop out of its single-shot request by itself.

Top module: `pwm2_ctrl`

## Requirements
- R1: After reset the control word reads 0, no ready flag is set, and every output sits at its inactive level. With the active-level bit at 0, the inactive level is high.
- R2: The control word is at address 0x0. Channel n's field occupies bits 15n+9..15n: bits 3:0 select the prescaler code, bit 4 enables, bit 5 sets the active level, bit 6 gates the clock, bit 7 selects single-shot mode, bit 8 is the single-shot request and bit 9 forces the undivided clock. The field reads back as written.
- R3: Prescaler codes 0, 1, 2, 3 and 4 give one tick every 120, 180, 240, 360 and 480 clocks. Codes 8, 9, 10, 11 and 12 give one tick every 12000, 24000, 36000, 48000 and 72000 clocks.
- R4: Code 15, or bit 9 set with any code, gives one tick per clock. Codes 5, 6, 7, 13 and 14 are invalid: a channel using one of them stays idle at its inactive level.
- R5: Channel n's period/duty word is at address 0x4 + 4n and reads back as written. Bits 31:16 hold the period in ticks minus one, and bits 15:0 hold the active-phase length in ticks. The output is active for the first duty ticks of each period of period+1 ticks.
- R6: A duty of period+1 or more keeps the output active for the whole period. A duty of 0 keeps it inactive.
- R7: A period/duty write to a running channel takes effect at the next period wrap. Ready bit 28+n reads 1 from the write until that copy. On an idle channel the copy happens one clock after the write.
- R8: A channel runs only while both its enable bit and its gate bit are 1. Otherwise it drives the inactive level. Clearing the gate resets the prescaler and the tick counter, so the next start begins at the first clock of the active phase.
- R9: With the active-level bit at 1 the output is high during the duty phase. With the bit at 0 the whole waveform is inverted.
- R10: With bit 7 at 1, the channel runs only while bit 8 is 1. It emits exactly one period and then clears bit 8 itself.
- R11: Writes to the ready bits and to the unused control bits have no effect.
- R12: The two channels are independent. Configuring channel 1 leaves channel 0's output and field unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the prescaler source |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe, one clock per write |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| pwm_out | output | NCH | One waveform output per channel |

## Verification
The waveform is exercised with a narrow duty, a duty wider than the period, a zero duty, an inverted level and a two-tick period. Together these separate the phase comparison from the wrap logic and from the polarity path. Both the low and the high prescaler ranges are measured by counting active clocks over whole periods, which exposes a wrong divisor. An invalid code and the bypass bit show that the table decode falls back correctly. Updates are written both mid-period and while idle, and the ready flag and the following waveform show when the shadow copy happened. A single-shot run and a run on channel 1 alone show that the request self-clears and that the channels stay apart.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;
  localparam int CH_STRIDE = 15;
  localparam int CFG_W     = 10;
  localparam int RDY_BASE  = 28;
  localparam int DIV_W     = 17;
  localparam int TICK_W    = 16;

  localparam int F_EN    = 4;
  localparam int F_ACT   = 5;
  localparam int F_GATE  = 6;
  localparam int F_MODE  = 7;
  localparam int F_PULSE = 8;
  localparam int F_BYP   = 9;

  typedef struct packed {
    logic       byp;
    logic       pulse;
    logic       mode;
    logic       gate;
    logic       act;
    logic       en;
    logic [3:0] code;
  } ch_cfg_t;

  // Clocks per prescaled tick; zero marks an unusable code.
  function automatic logic [DIV_W-1:0] code_divisor(input logic [3:0] code,
                                                    input logic byp,
                                                    input bit has_byp);
    logic [DIV_W-1:0] d;
    case (code)
      4'd0:    d = DIV_W'(120);
      4'd1:    d = DIV_W'(180);
      4'd2:    d = DIV_W'(240);
      4'd3:    d = DIV_W'(360);
      4'd4:    d = DIV_W'(480);
      4'd8:    d = DIV_W'(12000);
      4'd9:    d = DIV_W'(24000);
      4'd10:   d = DIV_W'(36000);
      4'd11:   d = DIV_W'(48000);
      4'd12:   d = DIV_W'(72000);
      4'd15:   d = has_byp ? DIV_W'(1) : '0;
      default: d = '0;
    endcase
    if (has_byp && byp) d = DIV_W'(1);
    return d;
  endfunction

  // Active phase: tick position lies before the duty count.
  function automatic logic in_duty(input logic [TICK_W-1:0] pos,
                                   input logic [TICK_W-1:0] dty);
    return pos < dty;
  endfunction
endpackage

// File: rtl/pwm2_prescaler.sv
module pwm2_prescaler
  import pwm2_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic [DIV_W-1:0] cnt_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             live;
  logic             at_end;

  assign live   = gate_i && (div_i != '0);
  assign at_end = cnt_q >= (div_i - DIV_W'(1));
  assign tick_o = live && at_end;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!live || at_end) cnt_q <= '0;
    else                      cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/pwm2_channel.sv
module pwm2_channel
  import pwm2_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ch_cfg_t           cfg_i,
  input  logic              div_ok_i,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [31:0]       wr_data_i,
  output logic              pwm_o,
  output logic              ready_o,
  output logic              load_o,
  output logic              wrap_o,
  output logic              done_o,
  output logic              run_o,
  output logic [31:0]       shadow_o,
  output logic [TICK_W-1:0] prd_o,
  output logic [TICK_W-1:0] dty_o,
  output logic [TICK_W-1:0] pos_o
);
  logic [31:0]       shadow_q;
  logic              pend_q;
  logic [TICK_W-1:0] prd_q, dty_q, pos_q;
  logic              run;

  assign run    = cfg_i.en && cfg_i.gate && div_ok_i && (!cfg_i.mode || cfg_i.pulse);
  assign wrap_o = run && tick_i && (pos_q == prd_q);
  assign load_o = pend_q && (!run || wrap_o);
  assign done_o = wrap_o && cfg_i.mode;
  assign run_o  = run;

  assign pwm_o    = (run && in_duty(pos_q, dty_q)) ? cfg_i.act : !cfg_i.act;
  assign ready_o  = pend_q;
  assign shadow_o = shadow_q;
  assign prd_o    = prd_q;
  assign dty_o    = dty_q;
  assign pos_o    = pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      pend_q   <= 1'b0;
    end else if (wr_i) begin
      shadow_q <= wr_data_i;
      pend_q   <= 1'b1;
    end else if (load_o) begin
      pend_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_q <= '0;
      dty_q <= '0;
    end else if (load_o) begin
      prd_q <= shadow_q[31:16];
      dty_q <= shadow_q[15:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pos_q <= '0;
    else if (!run)    pos_q <= '0;
    else if (wrap_o)  pos_q <= '0;
    else if (tick_i)  pos_q <= pos_q + 1'b1;
  end
endmodule

// File: rtl/pwm2_ctrl.sv
module pwm2_ctrl
  import pwm2_pkg::*;
#(
  parameter int NCH        = 2,
  parameter bit HAS_BYPASS = 1'b1,
  parameter int ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [NCH-1:0]    pwm_out
);
  function automatic logic [ADDR_W-1:0] chan_addr(input int n);
    return ADDR_W'(4 * n + 4);
  endfunction

  logic [NCH-1:0][CFG_W-1:0]  cfg_q;
  logic [NCH-1:0]             ready, load, wrap, pulse_done, run, tick, prd_wr;
  logic [NCH-1:0][DIV_W-1:0]  pcnt;
  logic [NCH-1:0][31:0]       shadow;
  logic [NCH-1:0][TICK_W-1:0] act_prd, act_dty, pos;
  logic                       ctrl_wr;
  logic                       unused_wdata;

  assign ctrl_wr      = reg_we && (reg_addr == '0);
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      for (int n = 0; n < NCH; n++) begin
        if (ctrl_wr)            cfg_q[n] <= reg_wdata[n*CH_STRIDE +: CFG_W];
        else if (pulse_done[n]) cfg_q[n][F_PULSE] <= 1'b0;
      end
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    ch_cfg_t          cfg_n;
    logic [DIV_W-1:0] div_n;

    assign cfg_n     = ch_cfg_t'(cfg_q[n]);
    assign div_n     = code_divisor(cfg_n.code, cfg_n.byp, HAS_BYPASS);
    assign prd_wr[n] = reg_we && (reg_addr == chan_addr(n));

    pwm2_prescaler u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .gate_i (cfg_n.gate),
      .div_i  (div_n),
      .tick_o (tick[n]),
      .cnt_o  (pcnt[n])
    );

    pwm2_channel u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_i     (cfg_n),
      .div_ok_i  (div_n != '0),
      .tick_i    (tick[n]),
      .wr_i      (prd_wr[n]),
      .wr_data_i (reg_wdata),
      .pwm_o     (pwm_out[n]),
      .ready_o   (ready[n]),
      .load_o    (load[n]),
      .wrap_o    (wrap[n]),
      .done_o    (pulse_done[n]),
      .run_o     (run[n]),
      .shadow_o  (shadow[n]),
      .prd_o     (act_prd[n]),
      .dty_o     (act_dty[n]),
      .pos_o     (pos[n])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == '0) begin
      for (int n = 0; n < NCH; n++) begin
        reg_rdata[n*CH_STRIDE +: CFG_W] = cfg_q[n];
        reg_rdata[RDY_BASE + n]         = ready[n];
      end
    end else begin
      for (int n = 0; n < NCH; n++)
        if (reg_addr == chan_addr(n)) reg_rdata = shadow[n];
    end
  end
endmodule

// File: rtl/pwm2_ctrl_chk.sv
module pwm2_ctrl_chk
  import pwm2_pkg::*;
#(
  parameter int NCH = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       ctrl_wr,
  input logic [NCH-1:0][CFG_W-1:0]  cfg_q,
  input logic [NCH-1:0]             ready,
  input logic [NCH-1:0]             load,
  input logic [NCH-1:0]             wrap,
  input logic [NCH-1:0]             pulse_done,
  input logic [NCH-1:0]             run,
  input logic [NCH-1:0][DIV_W-1:0]  pcnt,
  input logic [NCH-1:0][TICK_W-1:0] act_prd,
  input logic [NCH-1:0][TICK_W-1:0] act_dty,
  input logic [NCH-1:0][TICK_W-1:0] pos,
  input logic [NCH-1:0]             pwm_out
);
  for (genvar n = 0; n < NCH; n++) begin : g_chk
    assert_idle_inactive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_q[n][F_EN] || !cfg_q[n][F_GATE]) |-> (pwm_out[n] == !cfg_q[n][F_ACT]));

    assert_gate_clears_prescaler_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_q[n][F_GATE] |=> (pcnt[n] == '0));

    assert_ready_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ready[n] && !load[n]) |=> ready[n]);

    assert_active_only_on_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !load[n] |=> ($stable(act_prd[n]) && $stable(act_dty[n])));

    assert_full_duty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run[n] && (act_dty[n] > act_prd[n])) |-> (pwm_out[n] == cfg_q[n][F_ACT]));

    assert_wrap_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wrap[n] |=> (pos[n] == '0));

    assert_pulse_self_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_done[n] && !ctrl_wr) |=> !cfg_q[n][F_PULSE]);
  end
endmodule

bind pwm2_ctrl pwm2_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctrl_wr    (ctrl_wr),
  .cfg_q      (cfg_q),
  .ready      (ready),
  .load       (load),
  .wrap       (wrap),
  .pulse_done (pulse_done),
  .run        (run),
  .pcnt       (pcnt),
  .act_prd    (act_prd),
  .act_dty    (act_dty),
  .pos        (pos),
  .pwm_out    (pwm_out)
);

// File: tb/test_pwm2_ctrl.sv
module test_pwm2_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm2_ctrl i_pwm2_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pwm_out   (pwm_out)
  );

  // ---------------- behavioural reference ----------------
  int lo_tab[5] = '{120, 180, 240, 360, 480};
  int hi_tab[5] = '{12000, 24000, 36000, 48000, 72000};

  function automatic int ref_div(int code, bit byp);
    if (byp) return 1;
    if (code <= 4) return lo_tab[code];
    if (code >= 8 && code <= 12) return hi_tab[code - 8];
    if (code == 15) return 1;
    return 0;
  endfunction

  logic [9:0]  m_cfg[2];
  logic [31:0] m_shadow[2];
  bit          m_pend[2];
  int          m_prd[2], m_dty[2], m_pc[2], m_pos[2];

  function automatic bit m_run(int n);
    int d;
    d = ref_div(int'(m_cfg[n][3:0]), m_cfg[n][9]);
    return m_cfg[n][4] && m_cfg[n][6] && d > 0 && (!m_cfg[n][7] || m_cfg[n][8]);
  endfunction

  function automatic bit m_out(int n);
    bit a;
    a = m_cfg[n][5];
    return (m_run(n) && m_pos[n] < m_dty[n]) ? a : !a;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 0; n < 2; n++) begin
        m_cfg[n] = '0; m_shadow[n] = '0; m_pend[n] = 0;
        m_prd[n] = 0; m_dty[n] = 0; m_pc[n] = 0; m_pos[n] = 0;
      end
    end else begin
      for (int n = 0; n < 2; n++) begin
        int d; bit live, tk, rn, wp, ld;
        d    = ref_div(int'(m_cfg[n][3:0]), m_cfg[n][9]);
        live = m_cfg[n][6] && d > 0;
        tk   = live && m_pc[n] >= d - 1;
        rn   = m_run(n);
        wp   = rn && tk && m_pos[n] == m_prd[n];
        ld   = m_pend[n] && (!rn || wp);
        m_pc[n]  = (live && !tk) ? m_pc[n] + 1 : 0;
        if (!rn || wp) m_pos[n] = 0;
        else if (tk)   m_pos[n] = m_pos[n] + 1;
        if (ld) begin
          m_prd[n] = int'(m_shadow[n][31:16]);
          m_dty[n] = int'(m_shadow[n][15:0]);
        end
        if (reg_we && reg_addr == 4'(4 * n + 4)) begin
          m_shadow[n] = reg_wdata; m_pend[n] = 1;
        end else if (ld) m_pend[n] = 0;
        if (reg_we && reg_addr == 4'd0) m_cfg[n] = reg_wdata[n*15 +: 10];
        else if (wp && m_cfg[n][7]) m_cfg[n][8] = 1'b0;
      end
    end
  end

  // Per-clock comparison of both outputs against the reference (R5, R9).
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int n = 0; n < 2; n++) begin
        checks++;
        if (pwm_out[n] !== m_out(n)) begin
          errors++;
          $display("FAIL R5/R9 model ch%0d t=%0t actual=%0b expected=%0b",
                   n, $time, pwm_out[n], m_out(n));
        end
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic count_high(int n, int cyc, output int c);
    c = 0;
    repeat (cyc) begin
      if (pwm_out[n]) c++;
      @(negedge clk);
    end
  endtask

  task automatic idle(int cyc);
    repeat (cyc) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    logic [31:0] v;
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(0, v);
    chk("R1 ctrl after reset", v, 0);
    chk("R1 outputs inactive high", pwm_out, 2'b11);

    wr(4, {16'd3, 16'd1});
    rd(0, v);  chk("R7 ready set while idle copy pending", v[28], 1);
    idle(1);
    rd(0, v);  chk("R7 idle copy clears ready", v[28], 0);
    rd(4, v);  chk("R5 period word readback", v, 32'h0003_0001);

    wr(0, 32'h0000_007F);
    rd(0, v);  chk("R2 field readback", v, 32'h7F);
    count_high(0, 8, c); chk("R5 duty 1 of 4", c, 2);

    wr(4, {16'd3, 16'd4});
    rd(0, v);  chk("R7 ready after running write", v[28], 1);
    idle(6);
    count_high(0, 8, c); chk("R6 duty beyond period all active", c, 8);
    wr(4, {16'd3, 16'd0});
    idle(6);
    count_high(0, 8, c); chk("R6 zero duty all inactive", c, 0);

    wr(4, {16'd3, 16'd2});
    rd(0, v);  chk("R7 ready held until wrap", v[28], 1);
    idle(6);
    rd(0, v);  chk("R7 ready clear after wrap", v[28], 0);
    count_high(0, 8, c); chk("R7 new duty in force", c, 4);

    wr(4, {16'd3, 16'd1});
    idle(6);
    wr(0, 32'h0000_005F);
    count_high(0, 8, c); chk("R9 inverted level", c, 6);

    wr(0, 32'h0000_003F);
    count_high(0, 10, c); chk("R8 gate off idles", c, 0);
    wr(0, 32'h0000_006F);
    count_high(0, 10, c); chk("R8 enable off idles", c, 0);
    wr(0, 32'h0000_007F);
    chk("R8 restart at active phase", pwm_out[0], 1);

    wr(0, 32'h0000_0075);
    count_high(0, 20, c); chk("R4 invalid code idles", c, 0);
    wr(4, {16'd1, 16'd1});
    wr(0, 32'h0000_0273);
    count_high(0, 8, c); chk("R4 bypass bit divides by one", c, 4);

    wr(0, 32'h0000_0070);
    idle(300);
    count_high(0, 480, c); chk("R3 code 0 divides by 120", c, 240);
    wr(0, 32'h0000_0078);
    idle(24100);
    count_high(0, 48000, c); chk("R3 code 8 divides by 12000", c, 24000);

    wr(0, 32'h0000_006F);
    wr(4, {16'd3, 16'd1});
    wr(0, 32'h0000_01FF);
    count_high(0, 20, c); chk("R10 single period emitted", c, 1);
    rd(0, v);  chk("R10 request bit self-cleared", v[8], 0);

    wr(0, 32'h3000_7C00);
    rd(0, v);  chk("R11 read-only and spare bits ignored", v, 0);

    wr(8, {16'd1, 16'd1});
    wr(0, 32'h0000_0020 | (32'h7F << 15));
    rd(0, v);  chk("R12 channel 1 field placement", v, 32'h003F_8020);
    count_high(1, 8, c); chk("R12 channel 1 waveform", c, 4);
    chk("R12 channel 0 untouched", pwm_out[0], 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule